// File: doc/BRIEF.md
# CAN Message Buffer Filter

This block sits between a frame-level CAN protocol engine and a CPU-side configuration port. It holds a bank of message buffers. Each buffer has an identifier, a format bit (standard or extended), a remote-request bit, a direction (receive or transmit) and a transmit priority. When the engine delivers a completed frame header, the block decides which receive buffer takes the frame. Two acceptance masks govern that decision. One mask is shared by every buffer except the last. The last buffer has a mask of its own, so it can act as a catch-all path.

For transmission, the block keeps choosing among the pending transmit buffers and presents the winner's identifier to the engine. When the engine reports the frame as sent, the buffer is retired. A buffer that sent a remote request turns into an empty receiver, ready for the answer. When a remote frame arrives and matches a loaded data transmit buffer, that buffer is queued for sending, so the reply needs no CPU work. Each buffer shows a 2-bit state and has its own interrupt flag.

Top module: `canmb_bank`

## Requirements
- R1: After reset, every buffer is an empty receive buffer (state code 0), and so has standard format, identifier 0 and priority 0. Both masks are 0, and tx_req, rx_hit, rx_drop and all irq bits are 0.
- R2: A data frame matches buffer i when the format bit is equal and the identifier bits agree in every position where the governing mask bit is 0. A mask bit of 1 means don't care. Standard frames compare bits 10:0 and extended frames compare bits 28:0. Buffers 0 to NBUF-2 use the shared mask (mask_sel=0); buffer NBUF-1 uses its own mask (mask_sel=1).
- R3: A data frame is taken by the lowest-numbered matching receive buffer in state 0. That buffer goes to state 1 (full) and sets its irq bit. One cycle after rx_valid, rx_hit pulses with rx_idx naming the buffer.
- R4: When no matching receive buffer is empty, rx_drop pulses one cycle later. If some matching receive buffer is non-empty, the lowest-numbered one goes to state 3 (overrun).
- R5: Among transmit buffers in state 2 (pending), the smallest cfg_pri value wins, and ties go to the lower index. tx_req, tx_idx, tx_id, tx_ext and tx_rtr are registered, so they reflect a state change one cycle after it.
- R6: tx_done while tx_req is high retires the presented buffer. A data buffer goes to state 1 and sets its irq bit. The next winner, excluding the retired buffer, is presented on the same edge.
- R7: A retired buffer that sent a remote request becomes a receive buffer in state 0 with its remote bit cleared. A later matching data frame is stored in it.
- R8: A remote frame never enters a receive buffer. It is taken by the lowest-numbered transmit data buffer in state 1 that it matches under R2. That buffer goes to state 2 and rx_hit names it. With no such buffer, rx_drop pulses.
- R9: rel_we returns buffer rel_idx to state 0, and irq_clr bits clear the matching irq flags.
- R10: Every rx_valid gives exactly one of rx_hit or rx_drop on the following cycle.
- R11: A configuration write sets a buffer's fields. A receive buffer starts in state 0; a transmit buffer starts in state 2 when cfg_send is 1 and in state 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write buffer configuration |
| cfg_idx | input | IW | Buffer index to configure |
| cfg_id | input | IDW | Identifier |
| cfg_ext | input | 1 | 1 = extended format |
| cfg_rtr | input | 1 | 1 = remote request (transmit) |
| cfg_tx | input | 1 | 1 = transmit buffer |
| cfg_pri | input | PW | Transmit priority, lower wins |
| cfg_send | input | 1 | Transmit buffer starts pending |
| rel_we | input | 1 | Release a buffer to empty |
| rel_idx | input | IW | Buffer to release |
| mask_we | input | 1 | Write a mask |
| mask_sel | input | 1 | 0 = shared mask, 1 = last-buffer mask |
| mask_val | input | IDW | Mask value, 1 = don't care |
| rx_valid | input | 1 | Received frame header valid |
| rx_id | input | IDW | Received identifier |
| rx_ext | input | 1 | Received format |
| rx_rtr | input | 1 | Received frame is remote |
| rx_hit | output | 1 | Frame taken by a buffer |
| rx_drop | output | 1 | Frame not taken |
| rx_idx | output | IW | Buffer that took the frame |
| tx_req | output | 1 | A frame is presented for sending |
| tx_idx | output | IW | Presented buffer |
| tx_id | output | IDW | Presented identifier |
| tx_ext | output | 1 | Presented format |
| tx_rtr | output | 1 | Presented remote bit |
| tx_done | input | 1 | Engine sent the presented frame |
| irq_clr | input | NBUF | Clear interrupt flags |
| irq | output | NBUF | Per-buffer interrupt flags |
| buf_state | output | 2*NBUF | State codes, 2 bits per buffer |

## Verification
The assertions check three things on every cycle. First, each received header yields exactly one outcome. Second, a reported hit leaves its buffer non-empty. Third, the arbiter's choice beats every other pending buffer on priority and index, and a sent remote request leaves its buffer empty. The bench's scenarios are the only evidence for the rest: mask don't-care handling, format separation, the last buffer's catch-all role, overrun marking, the remote auto-reply, interrupt set and clear, and the exact sending order over several completions.

// File: rtl/canmb_pkg.sv
package canmb_pkg;
  typedef enum logic [1:0] {
    ST_EMPTY = 2'd0,
    ST_FULL  = 2'd1,
    ST_PEND  = 2'd2,
    ST_OVR   = 2'd3
  } mb_state_e;
endpackage

// File: rtl/canmb_match.sv
module canmb_match #(
  parameter int NBUF = 15,
  parameter int IDW  = 29,
  parameter int STDW = 11
) (
  input  logic [IDW-1:0]            rx_id,
  input  logic                      rx_ext,
  input  logic [NBUF-1:0][IDW-1:0]  buf_id,
  input  logic [NBUF-1:0]           buf_ext,
  input  logic [IDW-1:0]            mask_shared,
  input  logic [IDW-1:0]            mask_last,
  output logic [NBUF-1:0]           hit
);
  localparam logic [IDW-1:0] STD_SPAN = IDW'((64'd1 << STDW) - 64'd1);
  localparam logic [IDW-1:0] EXT_SPAN = '1;

  logic [IDW-1:0] span;
  assign span = rx_ext ? EXT_SPAN : STD_SPAN;

  for (genvar g = 0; g < NBUF; g++) begin : g_cmp
    logic [IDW-1:0] care;
    if (g == NBUF - 1) begin : g_last
      assign care = ~mask_last & span;
    end else begin : g_shared
      assign care = ~mask_shared & span;
    end
    assign hit[g] = (buf_ext[g] == rx_ext) && (((rx_id ^ buf_id[g]) & care) == '0);
  end
endmodule

// File: rtl/canmb_arb.sv
module canmb_arb #(
  parameter int NBUF = 15,
  parameter int PW   = 4,
  localparam int IW  = $clog2(NBUF)
) (
  input  logic [NBUF-1:0]          pend,
  input  logic [NBUF-1:0][PW-1:0]  pri,
  output logic                     valid,
  output logic [IW-1:0]            sel
);
  always_comb begin
    valid = 1'b0;
    sel   = '0;
    for (int i = NBUF - 1; i >= 0; i--) begin
      if (pend[i] && (!valid || pri[i] <= pri[sel])) begin
        valid = 1'b1;
        sel   = IW'(i);
      end
    end
  end

  always_comb begin
    if (valid) begin
      for (int j = 0; j < NBUF; j++) begin
        assert_best_pick_R5: assert (!pend[j] || pri[j] > pri[sel] ||
                                     (pri[j] == pri[sel] && j >= int'(sel)))
          else $error("arbiter picked a worse buffer");
      end
    end
  end
endmodule

// File: rtl/canmb_bank.sv
module canmb_bank
  import canmb_pkg::*;
#(
  parameter int NBUF = 15,
  parameter int IDW  = 29,
  parameter int STDW = 11,
  parameter int PW   = 4,
  localparam int IW  = $clog2(NBUF)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [IW-1:0]      cfg_idx,
  input  logic [IDW-1:0]     cfg_id,
  input  logic               cfg_ext,
  input  logic               cfg_rtr,
  input  logic               cfg_tx,
  input  logic [PW-1:0]      cfg_pri,
  input  logic               cfg_send,
  input  logic               rel_we,
  input  logic [IW-1:0]      rel_idx,
  input  logic               mask_we,
  input  logic               mask_sel,
  input  logic [IDW-1:0]     mask_val,
  input  logic               rx_valid,
  input  logic [IDW-1:0]     rx_id,
  input  logic               rx_ext,
  input  logic               rx_rtr,
  output logic               rx_hit,
  output logic               rx_drop,
  output logic [IW-1:0]      rx_idx,
  output logic               tx_req,
  output logic [IW-1:0]      tx_idx,
  output logic [IDW-1:0]     tx_id,
  output logic               tx_ext,
  output logic               tx_rtr,
  input  logic               tx_done,
  input  logic [NBUF-1:0]    irq_clr,
  output logic [NBUF-1:0]    irq,
  output logic [2*NBUF-1:0]  buf_state
);
  logic [NBUF-1:0][IDW-1:0] id_q;
  logic [NBUF-1:0][PW-1:0]  pri_q;
  logic [NBUF-1:0]          ext_q, rtr_q, dir_q;
  mb_state_e                st_q [NBUF];
  logic [IDW-1:0]           mask_sh_q, mask_ls_q;

  logic [NBUF-1:0] hit, take, full_rx, pend;
  logic            take_any, full_any, arb_valid, done_ok;
  logic [IW-1:0]   take_idx, full_idx, arb_sel;

  canmb_match #(.NBUF(NBUF), .IDW(IDW), .STDW(STDW)) i_match (
    .rx_id(rx_id), .rx_ext(rx_ext), .buf_id(id_q), .buf_ext(ext_q),
    .mask_shared(mask_sh_q), .mask_last(mask_ls_q), .hit(hit)
  );

  assign done_ok = tx_done && tx_req && (st_q[tx_idx] == ST_PEND);

  always_comb begin
    for (int i = 0; i < NBUF; i++) begin
      if (rx_rtr)
        take[i] = hit[i] && dir_q[i] && !rtr_q[i] && (st_q[i] == ST_FULL);
      else
        take[i] = hit[i] && !dir_q[i] && (st_q[i] == ST_EMPTY);
      full_rx[i] = hit[i] && !dir_q[i] && !rx_rtr && (st_q[i] != ST_EMPTY);
      pend[i]    = dir_q[i] && (st_q[i] == ST_PEND) && !(done_ok && tx_idx == IW'(i));
    end
    take_any = 1'b0; take_idx = '0;
    full_any = 1'b0; full_idx = '0;
    for (int i = NBUF - 1; i >= 0; i--) begin
      if (take[i])    begin take_any = 1'b1; take_idx = IW'(i); end
      if (full_rx[i]) begin full_any = 1'b1; full_idx = IW'(i); end
    end
  end

  canmb_arb #(.NBUF(NBUF), .PW(PW)) i_arb (
    .pend(pend), .pri(pri_q), .valid(arb_valid), .sel(arb_sel)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      id_q <= '0; pri_q <= '0; ext_q <= '0; rtr_q <= '0; dir_q <= '0;
      for (int i = 0; i < NBUF; i++) st_q[i] <= ST_EMPTY;
      mask_sh_q <= '0; mask_ls_q <= '0;
      irq <= '0;
      rx_hit <= 1'b0; rx_drop <= 1'b0; rx_idx <= '0;
      tx_req <= 1'b0; tx_idx <= '0; tx_id <= '0; tx_ext <= 1'b0; tx_rtr <= 1'b0;
    end else begin
      irq <= irq & ~irq_clr;
      rx_hit  <= rx_valid && take_any;
      rx_drop <= rx_valid && !take_any;
      if (rx_valid && take_any) rx_idx <= take_idx;
      if (rx_valid) begin
        if (take_any) begin
          st_q[take_idx] <= rx_rtr ? ST_PEND : ST_FULL;
          if (!rx_rtr) irq[take_idx] <= 1'b1;
        end else if (full_any) begin
          st_q[full_idx] <= ST_OVR;
        end
      end
      if (done_ok) begin
        irq[tx_idx] <= 1'b1;
        if (rtr_q[tx_idx]) begin
          dir_q[tx_idx] <= 1'b0;
          rtr_q[tx_idx] <= 1'b0;
          st_q[tx_idx]  <= ST_EMPTY;
        end else begin
          st_q[tx_idx]  <= ST_FULL;
        end
      end
      if (rel_we) st_q[rel_idx] <= ST_EMPTY;
      if (mask_we) begin
        if (mask_sel) mask_ls_q <= mask_val;
        else          mask_sh_q <= mask_val;
      end
      if (cfg_we) begin
        id_q[cfg_idx]  <= cfg_id;
        ext_q[cfg_idx] <= cfg_ext;
        rtr_q[cfg_idx] <= cfg_tx && cfg_rtr;
        dir_q[cfg_idx] <= cfg_tx;
        pri_q[cfg_idx] <= cfg_pri;
        st_q[cfg_idx]  <= !cfg_tx ? ST_EMPTY : (cfg_send ? ST_PEND : ST_FULL);
      end
      tx_req <= arb_valid;
      if (arb_valid) begin
        tx_idx <= arb_sel;
        tx_id  <= id_q[arb_sel];
        tx_ext <= ext_q[arb_sel];
        tx_rtr <= rtr_q[arb_sel];
      end
    end
  end

  for (genvar g = 0; g < NBUF; g++) begin : g_state
    assign buf_state[2*g +: 2] = st_q[g];
  end

  assert_one_outcome_R10: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> (rx_hit != rx_drop))
    else $error("rx outcome not unique");

  assert_quiet_outcome_R10: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |=> !rx_hit && !rx_drop)
    else $error("rx outcome without a frame");

  assert_hit_leaves_data_R3: assert property (@(posedge clk) disable iff (rst)
    rx_valid && !cfg_we && !rel_we |=> !rx_hit || (st_q[rx_idx] != ST_EMPTY))
    else $error("hit buffer left empty");

  assert_remote_turns_rx_R7: assert property (@(posedge clk) disable iff (rst)
    tx_done && tx_req && tx_rtr && (st_q[tx_idx] == ST_PEND) && !cfg_we
      |=> (st_q[$past(tx_idx)] == ST_EMPTY) && !dir_q[$past(tx_idx)])
    else $error("remote buffer not turned to receive");

  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> !tx_req && !rx_hit && !rx_drop && (irq == '0))
    else $error("outputs active after reset");
endmodule

// File: tb/test_canmb_bank.sv
module test_canmb_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NBUF = 15;
  localparam int IDW  = 29;
  localparam int PW   = 4;
  localparam int IW   = $clog2(NBUF);

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_we = 0, cfg_ext = 0, cfg_rtr = 0, cfg_tx = 0, cfg_send = 0;
  logic [IW-1:0] cfg_idx = '0, rel_idx = '0;
  logic [IDW-1:0] cfg_id = '0, mask_val = '0, rx_id = '0;
  logic [PW-1:0] cfg_pri = '0;
  logic rel_we = 0, mask_we = 0, mask_sel = 0;
  logic rx_valid = 0, rx_ext = 0, rx_rtr = 0, tx_done = 0;
  logic [NBUF-1:0] irq_clr = '0;
  logic rx_hit, rx_drop, tx_req, tx_ext, tx_rtr;
  logic [IW-1:0] rx_idx, tx_idx;
  logic [IDW-1:0] tx_id;
  logic [NBUF-1:0] irq;
  logic [2*NBUF-1:0] buf_state;

  int errors = 0, checks = 0;
  logic [IW:0] expq[$];

  canmb_bank i_canmb_bank (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && (rx_hit || rx_drop)) begin
      if (expq.size() == 0) check("R10 unexpected outcome", {rx_hit, rx_drop}, 0);
      else begin
        logic [IW:0] e;
        e = expq.pop_front();
        if (e[IW]) check("R4/R8 drop", {rx_hit, rx_drop}, 2'b01);
        else check("R3/R8 hit index", {rx_hit, rx_drop, 4'h0, rx_idx}, {2'b10, 4'h0, e[IW-1:0]});
      end
    end
  end

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic cfg(int idx, int id, bit ext, bit tx, bit rtr, int pri, bit send);
    cfg_we = 1; cfg_idx = IW'(idx); cfg_id = IDW'(id); cfg_ext = ext;
    cfg_tx = tx; cfg_rtr = rtr; cfg_pri = PW'(pri); cfg_send = send;
    tick(); cfg_we = 0;
  endtask

  task automatic set_mask(bit sel, int val);
    mask_we = 1; mask_sel = sel; mask_val = IDW'(val); tick(); mask_we = 0;
  endtask

  task automatic frame(int id, bit ext, bit rtr, bit drop, int idx);
    expq.push_back({drop, IW'(idx)});
    rx_valid = 1; rx_id = IDW'(id); rx_ext = ext; rx_rtr = rtr;
    tick(); rx_valid = 0; tick();
  endtask

  task automatic done(); tx_done = 1; tick(); tx_done = 0; endtask

  function automatic logic [1:0] st(int i); return buf_state[2*i +: 2]; endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tick(); tick(); rst = 0; tick();
    check("R1 states", buf_state, 0);
    check("R1 tx_req", tx_req, 0);
    check("R1 irq", irq, 0);
    set_mask(0, 'hF);
    set_mask(1, 'h1FFF_FFFF);
    cfg(0, 'h120, 0, 0, 0, 0, 0);
    cfg(1, 'h120, 0, 0, 0, 0, 0);
    frame('h125, 0, 0, 0, 0);           // R2 masked bits, R3 lowest wins
    frame('h123, 0, 0, 0, 1);           // R3 next empty
    check("R3 full state", st(0), 1);
    check("R3 irq", irq[1:0], 2'b11);
    frame('h121, 0, 0, 0, 14);          // R2 last buffer own mask
    frame('h12A, 0, 0, 1, 0);           // R4 overrun
    check("R4 overrun buf0", st(0), 3);
    frame('h300, 0, 0, 1, 0);
    check("R4 overrun buf14", st(14), 3);
    frame('h005, 0, 0, 0, 2);           // R1 default id 0 buffers
    rel_we = 1; rel_idx = 1; tick(); rel_we = 0;
    check("R9 release", st(1), 0);
    cfg(3, 'h123_4567, 1, 0, 0, 0, 0);
    frame('h123_456A, 1, 0, 0, 3);      // R2 extended format
    frame('h123_4567, 1, 0, 1, 0);
    check("R4 ext overrun", st(3), 3);
    cfg(5, 'h050, 0, 1, 0, 3, 1);
    cfg(6, 'h060, 0, 1, 0, 1, 1);
    cfg(7, 'h070, 0, 1, 0, 1, 1);       // R11 pending start
    check("R11 pending", st(7), 2);
    tick();
    check("R5 winner", {tx_req, tx_idx}, {1'b1, 4'd6});
    check("R5 id", tx_id, 'h060);
    done();
    check("R6 next", {tx_req, tx_idx}, {1'b1, 4'd7});
    check("R6 full", st(6), 1);
    check("R6 irq", irq[6], 1);
    done();
    check("R5 third", {tx_req, tx_idx}, {1'b1, 4'd5});
    done();
    check("R6 idle", tx_req, 0);
    cfg(8, 'h0AA, 0, 1, 1, 0, 1);
    tick();
    check("R7 remote presented", {tx_req, tx_idx, tx_rtr}, {1'b1, 4'd8, 1'b1});
    done();
    check("R7 empty", st(8), 0);
    frame('h0AA, 0, 0, 0, 8);
    check("R7 captured", st(8), 1);
    frame('h050, 0, 1, 0, 5);           // R8 auto reply
    check("R8 pending", st(5), 2);
    check("R8 presented", {tx_req, tx_idx, tx_rtr}, {1'b1, 4'd5, 1'b0});
    frame('h120, 0, 1, 1, 0);           // R8 remote not stored
    check("R8 rx untouched", st(1), 0);
    irq_clr = 15'h0001; tick(); irq_clr = '0;
    check("R9 irq clear", irq[0], 0);
    check("R9 other irq kept", irq[1], 1);
    tick(); tick();
    check("R10 queue drained", expq.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule